// File: doc/BRIEF.md
# Free-Running Timer with Coherent Byte Read

A 16-bit up-counter that never stops except under an explicit halt, exposed to a byte-wide register bus the way a small controller peripheral would be. Software reads the count through two equivalent register pairs: a main pair and an alternate pair. Each pair has a high byte and a low byte. If software reads the high byte first, the low byte is captured at that moment, so the two halves always belong to the same count value.

When the count wraps from its maximum to zero, an overflow flag is set in a status register. An interrupt line follows that flag, gated by an enable bit and an external mask input. Clearing the flag takes two ordered steps: a status read that sees the flag, then an access to the main low byte. Accesses through the alternate pair never disturb the flag. Software can therefore timestamp events without losing an overflow.

The count advances on one of two sources. The first is a free 4-bit prescaler that divides the system clock by 1, 4 or 16. The second is an external pin, brought in through a synchronizer, on a selectable edge.

Top module: `ftmr_top`

## Requirements
- R1: Register map by address: 0 control, 1 status (flag at bit 0, other bits 0), 2 main high, 3 main low, 4 alternate high, 5 alternate low, 6 and 7 read 0. Reading either high byte returns the live high byte of the count and, if no capture is pending, stores the live low byte. Writes to the counter addresses never change the count.
- R2: While a capture is pending, reading either low byte returns the stored byte and ends the pending state. Further high-byte reads in between do not replace the stored byte.
- R3: With no capture pending, reading either low byte returns the live low byte of the count.
- R4: Reset loads the count with 16'hFFFC and clears the flag. Every increment from 16'hFFFF to 16'h0000 sets the flag, whatever the source.
- R5: `ovf_irq` is high exactly when the flag is 1, control bit 0 (enable) is 1 and `int_mask` is 0. A set flag stays pending until these conditions hold.
- R6: The flag clears only when a status read has seen it set and a later read or write of address 3 occurs. An overflow before that access cancels the armed step, and the flag stays 1.
- R7: Reads and writes of addresses 4 and 5 never clear the flag and never arm or cancel the clear sequence.
- R8: While `halt` is 1 the count holds its value, and counting resumes from it when `halt` falls. The prescaler keeps running.
- R9: Control bits are [3:2] source (0 every cycle, 1 every 4th, 2 every 16th, 3 external), [1] external edge (1 rising, 0 falling) and [0] interrupt enable. All reset to 0. The internal tick fires when the low bits of the prescaler, counted from 0 after reset, are all ones for that ratio.
- R10: With source 3, each active edge of `ext_clk_in` advances the count by one, at the third rising clock edge after the pin changes. Active edges are at least four clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| halt | input | 1 | Freezes the counter while high |
| int_mask | input | 1 | Global interrupt mask, 1 blocks the request |
| ext_clk_in | input | 1 | Asynchronous external count pin |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
A stale or wrongly cleared pending-capture bit shows at the very next low-byte read, which returns the live byte instead of the stored one or the reverse. A wrongly armed or disarmed clear sequence shows one cycle after the access to address 3, at the next status read and immediately on `ovf_irq`. Errors in the prescaler phase or the synchronizer depth show as a count that drifts by one from the expected value at the next counter read.

// File: rtl/ftmr_pkg.sv
package ftmr_pkg;

    localparam int CNT_W   = 16;
    localparam int BYTE_W  = 8;
    localparam int ADDR_W  = 3;
    localparam int PRE_W   = 4;
    localparam int CTRL_W  = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 3'd0,
        A_STAT   = 3'd1,
        A_CNT_HI = 3'd2,
        A_CNT_LO = 3'd3,
        A_ALT_HI = 3'd4,
        A_ALT_LO = 3'd5
    } reg_addr_e;

    typedef enum logic [1:0] {
        SRC_DIV1  = 2'd0,
        SRC_DIV4  = 2'd1,
        SRC_DIV16 = 2'd2,
        SRC_EXT   = 2'd3
    } clk_src_e;

    typedef struct packed {
        clk_src_e src;
        logic     rise_edge;
        logic     ovf_ie;
    } ctrl_t;

    function automatic logic [PRE_W-1:0] pre_mask(input clk_src_e s);
        case (s)
            SRC_DIV4:  return PRE_W'(3);
            SRC_DIV16: return PRE_W'(15);
            default:   return '0;
        endcase
    endfunction

    function automatic logic addr_is_hi(input logic [ADDR_W-1:0] a);
        return (a == A_CNT_HI) || (a == A_ALT_HI);
    endfunction

    function automatic logic addr_is_lo(input logic [ADDR_W-1:0] a);
        return (a == A_CNT_LO) || (a == A_ALT_LO);
    endfunction

    function automatic logic addr_is_alt(input logic [ADDR_W-1:0] a);
        return (a == A_ALT_HI) || (a == A_ALT_LO);
    endfunction

endpackage

// File: rtl/ftmr_tick.sv
module ftmr_tick
    import ftmr_pkg::*;
#(
    parameter int SYNC_LEN = 2
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     ext_clk_in,
    input  clk_src_e src,
    input  logic     rise_edge,
    output logic     tick
);

    localparam int SH_W = SYNC_LEN + 1;

    logic [SH_W-1:0]  sh;
    logic [PRE_W-1:0] pre;
    logic             lvl;
    logic             prev;
    logic             ext_edge;
    logic             int_tick;

    for (genvar i = 0; i < SH_W; i++) begin : g_sync
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) sh[i] <= 1'b0;
                else     sh[i] <= ext_clk_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) sh[i] <= 1'b0;
                else     sh[i] <= sh[i-1];
            end
        end
    end

    assign lvl  = sh[SYNC_LEN-1];
    assign prev = sh[SYNC_LEN];

    always_comb begin
        if (rise_edge) ext_edge = lvl & ~prev;
        else           ext_edge = ~lvl & prev;
    end

    always_ff @(posedge clk) begin
        if (rst) pre <= '0;
        else     pre <= pre + PRE_W'(1);
    end

    assign int_tick = ((pre & pre_mask(src)) == pre_mask(src));
    assign tick     = (src == SRC_EXT) ? ext_edge : int_tick;

endmodule

// File: rtl/ftmr_counter.sv
module ftmr_counter
    import ftmr_pkg::*;
#(
    parameter logic [CNT_W-1:0] RST_COUNT = 16'hFFFC
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             halt,
    output logic [CNT_W-1:0] cnt,
    output logic             wrap
);

    logic step;

    assign step = tick & ~halt;
    assign wrap = step & (cnt == {CNT_W{1'b1}});

    always_ff @(posedge clk) begin
        if (rst)       cnt <= RST_COUNT;
        else if (step) cnt <= cnt + CNT_W'(1);
    end

    assert_step_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !halt) |=> cnt == CNT_W'($past(cnt) + CNT_W'(1)));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        halt |=> cnt == $past(cnt));

endmodule

// File: rtl/ftmr_regs.sv
module ftmr_regs
    import ftmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              wrap,
    input  logic              int_mask,
    output ctrl_t             ctrl,
    output logic              ovf_irq
);

    logic              rd_acc;
    logic              hi_rd;
    logic              lo_rd;
    logic              lo_main_acc;
    logic              stat_rd;
    logic              ctrl_wr;
    logic              pending;
    logic [BYTE_W-1:0] lo_buf;
    logic              flag;
    logic              armed;
    logic              unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[BYTE_W-1:CTRL_W];

    assign rd_acc      = bus_sel & ~bus_wr;
    assign hi_rd       = rd_acc & addr_is_hi(bus_addr);
    assign lo_rd       = rd_acc & addr_is_lo(bus_addr);
    assign lo_main_acc = bus_sel & (bus_addr == A_CNT_LO);
    assign stat_rd     = rd_acc & (bus_addr == A_STAT);
    assign ctrl_wr     = bus_sel & bus_wr & (bus_addr == A_CTRL);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (ctrl_wr) begin
            ctrl <= ctrl_t'(bus_wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending <= 1'b0;
            lo_buf  <= '0;
        end else if (hi_rd && !pending) begin
            pending <= 1'b1;
            lo_buf  <= cnt[BYTE_W-1:0];
        end else if (lo_rd) begin
            pending <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (wrap) begin
            flag  <= 1'b1;
            armed <= 1'b0;
        end else if (armed && lo_main_acc) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else if (stat_rd && flag) begin
            armed <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:   bus_rdata = BYTE_W'(ctrl);
            A_STAT:   bus_rdata = BYTE_W'(flag);
            A_CNT_HI,
            A_ALT_HI: bus_rdata = cnt[CNT_W-1:BYTE_W];
            A_CNT_LO,
            A_ALT_LO: bus_rdata = pending ? lo_buf : cnt[BYTE_W-1:0];
            default:  bus_rdata = '0;
        endcase
    end

    assign ovf_irq = flag & ctrl.ovf_ie & ~int_mask;

    assert_wrap_sets_R4: assert property (@(posedge clk) disable iff (rst)
        wrap |=> flag);

    assert_buf_kept_R2: assert property (@(posedge clk) disable iff (rst)
        (pending && !lo_rd) |=> $stable(lo_buf) && pending);

    assert_flag_kept_R6: assert property (@(posedge clk) disable iff (rst)
        (flag && !(armed && lo_main_acc)) |=> flag);

    assert_alt_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && addr_is_alt(bus_addr) && !wrap) |=>
            (flag == $past(flag)) && (armed == $past(armed)));

endmodule

// File: rtl/ftmr_top.sv
module ftmr_top
    import ftmr_pkg::*;
#(
    parameter int               SYNC_LEN  = 2,
    parameter logic [CNT_W-1:0] RST_COUNT = 16'hFFFC
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    input  logic              halt,
    input  logic              int_mask,
    input  logic              ext_clk_in,
    output logic              ovf_irq
);

    ctrl_t            ctrl;
    logic             tick;
    logic             wrap;
    logic [CNT_W-1:0] cnt;

    ftmr_tick #(.SYNC_LEN(SYNC_LEN)) u_tick (
        .clk        (clk),
        .rst        (rst),
        .ext_clk_in (ext_clk_in),
        .src        (ctrl.src),
        .rise_edge  (ctrl.rise_edge),
        .tick       (tick)
    );

    ftmr_counter #(.RST_COUNT(RST_COUNT)) u_cnt (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .halt (halt),
        .cnt  (cnt),
        .wrap (wrap)
    );

    ftmr_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .cnt       (cnt),
        .wrap      (wrap),
        .int_mask  (int_mask),
        .ctrl      (ctrl),
        .ovf_irq   (ovf_irq)
    );

endmodule

// File: tb/sim_ftmr_top.sv
`timescale 1ns/1ps
module sim_ftmr_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       halt = 1'b1;
    logic       int_mask = 1'b0;
    logic       ext_clk_in = 1'b0;
    logic       ovf_irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    ftmr_top u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .halt(halt), .int_mask(int_mask), .ext_clk_in(ext_clk_in),
        .ovf_irq(ovf_irq)
    );

    // Reference model built from the requirements
    logic [15:0] m_cnt;
    logic        m_flag, m_arm, m_pend;
    logic [7:0]  m_buf;
    logic [3:0]  m_ctrl, m_pre;
    logic [2:0]  m_s;
    logic        t_int, t_ext, t_inc, t_wrap, t_rd;

    always @(posedge clk) begin
        if (rst) begin
            m_cnt = 16'hFFFC; m_flag = 0; m_arm = 0; m_pend = 0;
            m_buf = 0; m_ctrl = 0; m_pre = 0; m_s = 0;
        end else begin
            case (m_ctrl[3:2])
                2'd0: t_int = 1'b1;
                2'd1: t_int = (m_pre[1:0] == 2'd3);
                2'd2: t_int = (m_pre == 4'd15);
                default: t_int = 1'b0;
            endcase
            t_ext  = m_ctrl[1] ? (m_s[1] & ~m_s[2]) : (~m_s[1] & m_s[2]);
            t_inc  = (m_ctrl[3:2] == 2'd3) ? t_ext : t_int;
            t_wrap = t_inc && !halt && (m_cnt == 16'hFFFF);
            t_rd   = bus_sel && !bus_wr;
            if (t_rd && (bus_addr == 3'd2 || bus_addr == 3'd4) && !m_pend) begin
                m_pend = 1; m_buf = m_cnt[7:0];
            end else if (t_rd && (bus_addr == 3'd3 || bus_addr == 3'd5)) begin
                m_pend = 0;
            end
            if (t_wrap) begin
                m_flag = 1; m_arm = 0;
            end else if (m_arm && bus_sel && bus_addr == 3'd3) begin
                m_flag = 0; m_arm = 0;
            end else if (t_rd && bus_addr == 3'd1 && m_flag) begin
                m_arm = 1;
            end
            if (bus_sel && bus_wr && bus_addr == 3'd0) m_ctrl = bus_wdata[3:0];
            if (t_inc && !halt) m_cnt = m_cnt + 16'd1;
            m_pre = m_pre + 4'd1;
            m_s   = {m_s[1:0], ext_clk_in};
        end
    end

    function automatic logic [7:0] exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return {4'd0, m_ctrl};
            3'd1: return {7'd0, m_flag};
            3'd2, 3'd4: return m_cnt[15:8];
            3'd3, 3'd5: return m_pend ? m_buf : m_cnt[7:0];
            default: return 8'd0;
        endcase
    endfunction

    function automatic string tag_for(input logic [2:0] a);
        case (a)
            3'd0: return "R9";
            3'd1: return "R4";
            3'd3, 3'd5: return m_pend ? "R2" : "R3";
            default: return "R1";
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // R5: request line compared every cycle
    always begin
        @(negedge clk);
        #2;
        if (!rst && !done)
            chk("R5", ovf_irq, m_flag & m_ctrl[0] & ~int_mask);
    end

    task automatic op(input logic w, input logic [2:0] a, input logic [7:0] d,
                      output logic [7:0] r);
        bus_sel = 1; bus_wr = w; bus_addr = a; bus_wdata = d;
        #1;
        r = bus_rdata;
        if (!w) chk(tag_for(a), r, exp_rd(a));
        @(negedge clk);
        bus_sel = 0; bus_wr = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic do_reset();
        halt = 1; rst = 1;
        idle(3);
        rst = 0;
    endtask

    task automatic rd_count(output logic [15:0] c);
        logic [7:0] h, l;
        op(0, 3'd2, 0, h);
        op(0, 3'd3, 0, l);
        c = {h, l};
    endtask

    task automatic ext_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            ext_clk_in = 1; idle(6);
            ext_clk_in = 0; idle(6);
        end
    endtask

    initial begin
        #(10 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [7:0]  r;
        logic [15:0] c0, c1;
        int          since;
        void'($urandom(32'd1234));
        @(negedge clk);
        do_reset();

        // Reset state
        op(0, 3'd0, 0, r); chk("R9 ctrl reset", r, 8'h00);
        op(0, 3'd1, 0, r); chk("R4 flag reset", r, 8'h00);
        chk("R5 irq reset", ovf_irq, 0);
        op(0, 3'd2, 0, r); chk("R1 hi reset", r, 8'hFF);
        op(0, 3'd3, 0, r); chk("R2 lo buffered", r, 8'hFC);
        op(0, 3'd6, 0, r); chk("R1 unmapped", r, 8'h00);

        // Coherent read across counting
        halt = 0; idle(10); halt = 1;
        op(0, 3'd2, 0, r); chk("R1 hi after wrap", r, 8'h00);
        halt = 0; idle(3); halt = 1;
        op(0, 3'd4, 0, r); chk("R2 second hi read", r, 8'h00);
        op(0, 3'd3, 0, r); chk("R2 buffer kept", r, 8'h06);
        op(0, 3'd3, 0, r); chk("R3 live lo", r, 8'h09);
        op(0, 3'd1, 0, r); chk("R4 wrap sets flag", r, 8'h01);

        // Alternate accesses leave the flag and arming alone
        op(0, 3'd5, 0, r);
        op(1, 3'd4, 8'h55, r);
        op(1, 3'd5, 8'hAA, r);
        op(0, 3'd1, 0, r); chk("R7 flag after alt", r, 8'h01);
        op(1, 3'd3, 8'h00, r);
        op(0, 3'd1, 0, r); chk("R6 cleared", r, 8'h00);
        op(0, 3'd3, 0, r); chk("R1 write no effect", r, 8'h09);

        // Clear needs the status read first, and new overflow cancels arming
        do_reset();
        halt = 0; idle(5); halt = 1;
        op(1, 3'd3, 8'h00, r);
        op(0, 3'd1, 0, r); chk("R6 lo access alone", r, 8'h01);
        halt = 0; idle(65536); halt = 1;
        op(1, 3'd3, 8'h00, r);
        op(0, 3'd1, 0, r); chk("R6 arm dropped", r, 8'h01);
        op(0, 3'd3, 0, r);
        op(0, 3'd1, 0, r); chk("R6 clear by read", r, 8'h00);

        // Halt hold and interrupt gating
        do_reset();
        halt = 0; idle(5); halt = 1;
        idle(20);
        rd_count(c0); chk("R8 held", c0, 16'h0001);
        chk("R5 disabled", ovf_irq, 0);
        op(1, 3'd0, 8'h01, r);
        chk("R5 enabled", ovf_irq, 1);
        int_mask = 1; #1; chk("R5 masked", ovf_irq, 0);
        int_mask = 0; #1; chk("R5 pending issued", ovf_irq, 1);

        // Prescaler ratios
        op(1, 3'd0, 8'h04, r);
        rd_count(c0); halt = 0; idle(40); halt = 1; rd_count(c1);
        chk("R9 div4", c1 - c0, 10);
        op(1, 3'd0, 8'h08, r);
        rd_count(c0); halt = 0; idle(64); halt = 1; rd_count(c1);
        chk("R9 div16", c1 - c0, 4);

        // External source, both edges
        halt = 0;
        op(1, 3'd0, 8'h0E, r);
        idle(6);
        rd_count(c0); ext_pulses(3); rd_count(c1);
        chk("R10 rising", c1 - c0, 3);
        op(1, 3'd0, 8'h0C, r);
        idle(6);
        rd_count(c0); ext_pulses(3); rd_count(c1);
        chk("R10 falling", c1 - c0, 3);

        // Constrained random traffic against the model
        since = 0;
        for (int i = 0; i < 4000; i++) begin
            if (($urandom % 10) == 0) halt = ~halt;
            if (($urandom % 16) == 0) int_mask = ~int_mask;
            since++;
            if (since >= 4 && ($urandom % 3) == 0) begin
                ext_clk_in = ~ext_clk_in; since = 0;
            end
            if (($urandom % 2) == 0) begin
                logic w;
                logic [2:0] a;
                w = (($urandom % 5) == 0);
                a = 3'($urandom % 8);
                if (w && a == 3'd0 && ($urandom % 4) != 0) a = 3'd5;
                op(w, a, 8'($urandom), r);
            end else begin
                idle(1);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule